// File: doc/BRIEF.md
# Per-Core Memory Dependency Logger

This block sits beside one core of a cache-coherent multiprocessor and records the cross-thread memory dependencies that a replay system later needs to rebuild the same access interleaving. It keeps a count of retired instructions. For every line in a small table indexed by cache-line slot, it also keeps the count of the most recent local load or store to that line. When another core probes a line, the block answers one cycle later with that stored count and its own core number. The coherence fabric carries this pair back to the requester.

On the requesting side, the block receives the pair when a local request is answered. It decides whether a dependency record must be written. A per-source-core vector holds the newest count already logged from each other core. A new answer whose count is no larger than that entry is already implied by an earlier record, so it is dropped. Any other answer produces a record of three fields: the source core, the source count and the local instruction count. It also raises the vector entry. Records leave through a valid/ready port from a small queue. When that queue is close to full and the consumer is not ready, a stall signal holds back retirement.

Top module: `mdl_logger`

## Requirements
- R1: After reset the instruction count is zero, every line count is zero (a probe of any line returns 0), every vector entry is zero, and logValid, rspValid and stall are low.
- R2: Each cycle with retireValid high and stall low raises the instruction count by one. The count appears as logDstCount in any record created while it holds that value.
- R3: An accepted retirement with retireMem high writes the new instruction count (old count plus one) into the line at retireLine. A later probe of that line returns the value on rspCount with rspCore equal to the MY_ID parameter.
- R4: rspValid is high in exactly the cycle after a cycle with probeValid high. rspCount carries the line count read for that probe.
- R5: When an accepted memory retirement and a probe target the same line in the same cycle, the probe returns the post-access count. A probe of a different line in that cycle returns that line's unchanged count.
- R6: An inbound response (inRspValid) whose inRspCount is strictly greater than the vector entry of core inRspCore creates a record {logSrcCore = inRspCore, logSrcCount = inRspCount, logDstCount = current instruction count}. It also sets that vector entry to inRspCount.
- R7: An inbound response whose count is less than or equal to its source core's vector entry creates no record and leaves the vector unchanged. Entries of different source cores are independent.
- R8: Records leave in creation order. While logValid is high and logReady is low, the head record stays valid and unchanged.
- R9: stall is high exactly when the queue holds DEPTH-1 or more records and logReady is low. While stall is high, retirements are ignored: neither the count nor any line count changes.
- R10: No created record is lost, provided inbound responses arrive only in cycles where stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | One instruction retires this cycle |
| retireMem | input | 1 | The retiring instruction is a load or store |
| retireLine | input | LINE_W | Line slot touched by the retiring access |
| probeValid | input | 1 | Remote coherence probe arrives |
| probeLine | input | LINE_W | Line slot the probe hits |
| rspValid | output | 1 | Probe answer valid (one cycle after probe) |
| rspCount | output | COUNT_W | Stored count of the probed line |
| rspCore | output | CORE_W | This core's number |
| inRspValid | input | 1 | Answer to a local request arrives |
| inRspCore | input | CORE_W | Core that answered |
| inRspCount | input | COUNT_W | Line count the answering core returned |
| logValid | output | 1 | Head record is available |
| logReady | input | 1 | Consumer takes the head record |
| logSrcCore | output | CORE_W | Record: source core |
| logSrcCount | output | COUNT_W | Record: source line count |
| logDstCount | output | COUNT_W | Record: local instruction count |
| stall | output | 1 | Hold retirement |

## Verification
The bench sweeps every line slot over several rounds of mixed plain and memory retirements. It tracks the expected count of each line arithmetically, so a design that stored the pre-increment count or wrote the wrong slot returns a wrong probe answer. It places a same-cycle access and probe on one line and on two different lines. A design without the forwarding path would return the stale count. For every source core it runs a series of counts that includes equal, smaller and larger values. A design that compared with greater-or-equal, updated the vector on suppressed answers or shared one entry across cores would then emit extra records or miss records. It fills the queue with the consumer held off and checks the order of records, the stability of the head, and that a retirement during the stall changes neither the count nor any line.

// File: rtl/mdl_pkg.sv
package mdl_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic cntEn;   // accept a retirement: advance instruction count
    logic lineWr;  // accepted retirement is a memory access: stamp line
    logic push;    // enqueue a dependency record
    logic pop;     // consumer takes the head record
    logic vecWr;   // raise the per-source vector entry
  } mdlStrobes_t;

endpackage

// File: rtl/mdl_ctrl.sv
module mdl_ctrl
  import mdl_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        retireValid,
  input  logic        retireMem,
  input  logic        inRspValid,
  input  logic        newer,
  input  logic        logReady,
  output mdlStrobes_t stb,
  output logic        logValid,
  output logic        stall
);

  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [OCC_W-1:0] occ;
  logic             full;
  logic             nearFull;

  assign full     = (occ == OCC_W'(DEPTH));
  assign nearFull = (occ >= OCC_W'(DEPTH - 1));
  assign logValid = (occ != '0);
  assign stall    = nearFull && !logReady;

  always_comb begin
    stb        = '0;
    stb.pop    = logValid && logReady;
    stb.cntEn  = retireValid && !stall;
    stb.lineWr = stb.cntEn && retireMem;
    stb.push   = inRspValid && newer && (!full || stb.pop);
    stb.vecWr  = stb.push;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
    end else if (stb.push && !stb.pop) begin
      occ <= occ + 1'b1;
    end else if (stb.pop && !stb.push) begin
      occ <= occ - 1'b1;
    end
  end

endmodule

// File: rtl/mdl_dpath.sv
module mdl_dpath
  import mdl_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  parameter int COUNT_W   = 16,
  parameter int DEPTH     = 4,
  localparam int CORE_W   = $clog2(NUM_CORES),
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  mdlStrobes_t        stb,
  input  logic [LINE_W-1:0]  retireLine,
  input  logic               probeValid,
  input  logic [LINE_W-1:0]  probeLine,
  input  logic [CORE_W-1:0]  inRspCore,
  input  logic [COUNT_W-1:0] inRspCount,
  output logic               newer,
  output logic               rspValid,
  output logic [COUNT_W-1:0] rspCount,
  output logic [COUNT_W-1:0] curCount,
  output logic [CORE_W-1:0]  headCore,
  output logic [COUNT_W-1:0] headSrc,
  output logic [COUNT_W-1:0] headDst
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int REC_W = CORE_W + 2 * COUNT_W;

  logic [COUNT_W-1:0] instrCnt;
  logic [COUNT_W-1:0] nextCnt;
  logic [COUNT_W-1:0] lineCnt [NUM_LINES];
  logic [COUNT_W-1:0] seenVec [NUM_CORES];
  logic [REC_W-1:0]   recMem  [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic               probeBypass;

  assign nextCnt  = instrCnt + 1'b1;
  assign curCount = instrCnt;

  // Retired-instruction counter
  always_ff @(posedge clk) begin
    if (!rst_n)         instrCnt <= '0;
    else if (stb.cntEn) instrCnt <= nextCnt;
  end

  // Per-line last-access count table
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rst_n)
        lineCnt[g] <= '0;
      else if (stb.lineWr && retireLine == LINE_W'(g))
        lineCnt[g] <= nextCnt;
    end
  end

  // Probe answer: local access of the same cycle wins over the stored value
  assign probeBypass = stb.lineWr && (retireLine == probeLine);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspCount <= '0;
    end else begin
      rspValid <= probeValid;
      if (probeValid)
        rspCount <= probeBypass ? nextCnt : lineCnt[probeLine];
    end
  end

  // Per-source vector for transitive reduction
  assign newer = inRspCount > seenVec[inRspCore];

  for (genvar c = 0; c < NUM_CORES; c++) begin : gVec
    always_ff @(posedge clk) begin
      if (!rst_n)
        seenVec[c] <= '0;
      else if (stb.vecWr && inRspCore == CORE_W'(c))
        seenVec[c] <= inRspCount;
    end
  end

  // Record queue storage and pointers
  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.push) wrPtr <= bump(wrPtr);
      if (stb.pop)  rdPtr <= bump(rdPtr);
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : gRec
    always_ff @(posedge clk) begin
      if (!rst_n)
        recMem[e] <= '0;
      else if (stb.push && wrPtr == PTR_W'(e))
        recMem[e] <= {inRspCore, inRspCount, instrCnt};
    end
  end

  assign {headCore, headSrc, headDst} = recMem[rdPtr];

endmodule

// File: rtl/mdl_logger.sv
module mdl_logger
  import mdl_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  parameter int COUNT_W   = 16,
  parameter int DEPTH     = 4,
  parameter int MY_ID     = 0,
  localparam int CORE_W   = $clog2(NUM_CORES),
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               retireValid,
  input  logic               retireMem,
  input  logic [LINE_W-1:0]  retireLine,
  input  logic               probeValid,
  input  logic [LINE_W-1:0]  probeLine,
  output logic               rspValid,
  output logic [COUNT_W-1:0] rspCount,
  output logic [CORE_W-1:0]  rspCore,
  input  logic               inRspValid,
  input  logic [CORE_W-1:0]  inRspCore,
  input  logic [COUNT_W-1:0] inRspCount,
  output logic               logValid,
  input  logic               logReady,
  output logic [CORE_W-1:0]  logSrcCore,
  output logic [COUNT_W-1:0] logSrcCount,
  output logic [COUNT_W-1:0] logDstCount,
  output logic               stall
);

  mdlStrobes_t        stb;
  logic               newer;
  logic [COUNT_W-1:0] curCount;

  assign rspCore = CORE_W'(MY_ID);

  mdl_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .retireValid(retireValid), .retireMem(retireMem),
    .inRspValid(inRspValid), .newer(newer), .logReady(logReady),
    .stb(stb), .logValid(logValid), .stall(stall)
  );

  mdl_dpath #(
    .NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES),
    .COUNT_W(COUNT_W), .DEPTH(DEPTH)
  ) dpath_i (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .retireLine(retireLine), .probeValid(probeValid), .probeLine(probeLine),
    .inRspCore(inRspCore), .inRspCount(inRspCount), .newer(newer),
    .rspValid(rspValid), .rspCount(rspCount), .curCount(curCount),
    .headCore(logSrcCore), .headSrc(logSrcCount), .headDst(logDstCount)
  );

endmodule

// File: rtl/mdl_logger_chk.sv
module mdl_logger_chk #(
  parameter int CORE_W  = 2,
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               retireValid,
  input logic               probeValid,
  input logic               rspValid,
  input logic               logValid,
  input logic               logReady,
  input logic [CORE_W-1:0]  logSrcCore,
  input logic [COUNT_W-1:0] logSrcCount,
  input logic [COUNT_W-1:0] logDstCount,
  input logic               stall,
  input logic [COUNT_W-1:0] curCount
);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (retireValid && !stall) |=> curCount == COUNT_W'($past(curCount) + 1'b1));

  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!retireValid || stall) |=> $stable(curCount));

  p_rsp_after_probe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    probeValid |=> rspValid);

  p_rsp_only_probe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !probeValid |=> !rspValid);

  p_stall_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (logValid && !logReady));

  p_head_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (logValid && !logReady) |=> (logValid && $stable(logSrcCore)
                                 && $stable(logSrcCount) && $stable(logDstCount)));

endmodule

bind mdl_logger mdl_logger_chk #(.CORE_W(CORE_W), .COUNT_W(COUNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .retireValid(retireValid), .probeValid(probeValid),
  .rspValid(rspValid), .logValid(logValid), .logReady(logReady),
  .logSrcCore(logSrcCore), .logSrcCount(logSrcCount), .logDstCount(logDstCount),
  .stall(stall), .curCount(curCount)
);

// File: tb/mdl_logger_tb.sv
module mdl_logger_tb_top;

  localparam int CORES = 4;
  localparam int LINES = 4;
  localparam int CW    = 16;
  localparam int DEPTH = 3;
  localparam int MYID  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          retireValid = 0, retireMem = 0;
  logic [1:0]    retireLine = '0;
  logic          probeValid = 0;
  logic [1:0]    probeLine = '0;
  logic          rspValid;
  logic [CW-1:0] rspCount;
  logic [1:0]    rspCore;
  logic          inRspValid = 0;
  logic [1:0]    inRspCore = '0;
  logic [CW-1:0] inRspCount = '0;
  logic          logValid;
  logic          logReady = 0;
  logic [1:0]    logSrcCore;
  logic [CW-1:0] logSrcCount, logDstCount;
  logic          stall;

  always #10 clk = ~clk;

  mdl_logger #(.NUM_CORES(CORES), .NUM_LINES(LINES), .COUNT_W(CW),
               .DEPTH(DEPTH), .MY_ID(MYID)) dut_i (.*);

  int nChecks = 0, nFails = 0;
  bit done = 0;
  int mCnt = 0;
  int mLine [LINES];
  int mVec  [CORES];
  int qCore [16], qSrc [16], qDst [16];
  int qHead = 0, qTail = 0;

  task automatic check(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
  endtask

  task automatic retire(bit isMem, int line);
    bit st = stall;
    retireValid = 1; retireMem = isMem; retireLine = line[1:0];
    cycle();
    retireValid = 0; retireMem = 0;
    if (!st) begin
      mCnt++;
      if (isMem) mLine[line] = mCnt;
    end
  endtask

  // Probe a line, optionally with a same-cycle memory retirement
  task automatic probeCheck(int line, bit withAcc, int accLine, string req);
    bit st = stall;
    probeValid = 1; probeLine = line[1:0];
    if (withAcc) begin
      retireValid = 1; retireMem = 1; retireLine = accLine[1:0];
    end
    cycle();
    probeValid = 0; retireValid = 0; retireMem = 0;
    if (withAcc && !st) begin
      mCnt++;
      mLine[accLine] = mCnt;
    end
    check(rspValid == 1'b1, {req, " R4 rspValid"}, rspValid, 1);
    check(rspCount == CW'(mLine[line]), {req, " rspCount"}, rspCount, mLine[line]);
    check(rspCore == 2'(MYID), "R3 rspCore", rspCore, MYID);
    cycle();
    check(rspValid == 1'b0, "R4 rspValid drop", rspValid, 0);
  endtask

  task automatic sendRsp(int core, int cnt);
    inRspValid = 1; inRspCore = core[1:0]; inRspCount = CW'(cnt);
    cycle();
    inRspValid = 0;
    if (cnt > mVec[core]) begin
      qCore[qTail % 16] = core; qSrc[qTail % 16] = cnt; qDst[qTail % 16] = mCnt;
      qTail++;
      mVec[core] = cnt;
    end
  endtask

  task automatic checkHead(string req);
    bit expV = (qHead != qTail);
    check(logValid == expV, {req, " logValid"}, logValid, expV);
    if (expV && logValid) begin
      check(logSrcCore == 2'(qCore[qHead % 16]), {req, " logSrcCore"}, logSrcCore, qCore[qHead % 16]);
      check(logSrcCount == CW'(qSrc[qHead % 16]), {req, " logSrcCount"}, logSrcCount, qSrc[qHead % 16]);
      check(logDstCount == CW'(qDst[qHead % 16]), {req, " logDstCount"}, logDstCount, qDst[qHead % 16]);
    end
  endtask

  task automatic drain(string req);
    logReady = 1;
    while (qHead != qTail) begin
      checkHead(req);
      cycle();
      qHead++;
    end
    logReady = 0;
    #1;
    check(logValid == 1'b0, {req, " empty after drain"}, logValid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) mLine[i] = 0;
    for (int i = 0; i < CORES; i++) mVec[i] = 0;
    repeat (3) cycle();
    // R1: reset state
    check(logValid == 0, "R1 logValid", logValid, 0);
    check(stall == 0, "R1 stall", stall, 0);
    check(rspValid == 0, "R1 rspValid", rspValid, 0);
    rst_n = 1;
    cycle();
    for (int l = 0; l < LINES; l++) probeCheck(l, 0, 0, "R1 line zero");

    // R3: sweep all lines with mixed retirements
    for (int r = 0; r < 3; r++) begin
      for (int l = 0; l < LINES; l++) begin
        for (int k = 0; k <= r + l; k++) retire(0, 0);
        retire(1, (l + r) % LINES);
      end
      for (int l = 0; l < LINES; l++) probeCheck(l, 0, 0, "R3 line stamp");
    end

    // R5: same-cycle access and probe
    probeCheck(1, 1, 1, "R5 same line");
    probeCheck(2, 1, 3, "R5 other line");
    probeCheck(3, 0, 0, "R5 other line stamped");

    // R6 / R2: first record carries current count
    retire(0, 0); retire(0, 0);
    sendRsp(0, 5);
    checkHead("R6 R2 first record");
    drain("R6");

    // R7: reduction sweep per source core
    for (int c = 0; c < CORES; c++) begin
      int seq [7] = '{4, 4, 2, 9, 9, 8, 12};
      for (int s = 0; s < 7; s++) begin
        retire(0, 0);
        sendRsp(c, seq[s] + c);
        checkHead("R7 R6 reduction");
        drain("R7");
      end
    end

    // R8 / R9 / R10: fill queue with consumer held off
    logReady = 0;
    sendRsp(1, 50);
    check(stall == 0, "R9 stall low below threshold", stall, 0);
    sendRsp(2, 60);
    #1;
    check(stall == 1, "R9 stall high at threshold", stall, 1);
    for (int k = 0; k < 3; k++) begin
      checkHead("R8 head hold");
      cycle();
    end
    retire(1, 0);
    retire(0, 0);
    probeCheck(0, 0, 0, "R9 retire ignored");
    checkHead("R8 head after stall");
    logReady = 1;
    #1;
    check(stall == 0, "R9 stall releases on ready", stall, 0);
    drain("R10 R8 order");
    retire(1, 0);
    probeCheck(0, 0, 0, "R9 retire after release");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule